// File: doc/BRIEF.md
# APB-to-OPB Transaction Bridge

This block is an APB slave register file that turns transactions set up by software into single transfers on one of two on-chip peripheral bus master channels. Software loads a channel's target address, write data, access width and direction into that channel's register set. It then marks the channel as selected and writes the shared trigger register. The bridge issues one request on the selected channel and holds the APB access with PREADY low until the channel answers with an acknowledge or an error.

A successful transfer sets that channel's acknowledge bit in the interrupt status register, and the interrupt output is high while either bit is set. Software clears each bit by writing a one to it. Read data from a successful read is zero-extended to the access width and stored in that channel's read data register. A bus error leaves both the status and the read data untouched. A bank of endian configuration registers holds fixed reset values. Writing a value to one of the channel 0 entries that is not the required big-endian setting raises a sticky configuration-error output, and the value is stored anyway.

Top module: `opb_bridge`

## Requirements
- R1: After reset, offset 0x000 reads 0x000000A1, the endian registers read 0x4C=0x0044EEE4, 0x50=0x0055AAFF, 0x54=0x00117717, 0x58=0xFFAA5500, 0x5C=0x0044EEE4 and 0x60=0x00117717, and all other registers, irq_o and cfg_err_o read zero.
- R2: Channel 0 registers select, mode, width, address and write data sit at 0x10, 0x14, 0x18, 0x1C and 0x20, and channel 1 registers at 0x28, 0x2C, 0x30, 0x34 and 0x38. Each of them reads back the last word written to it.
- R3: A write to the trigger at 0x04, when exactly one channel has select bit 0 set, issues exactly one request on that channel. The request carries the address register and a write-enable equal to the inverse of mode bit 0 (1 means read). The APB access stays stalled until the cycle in which the channel returns acknowledge or error, and the request outputs hold stable while it waits.
- R4: The width register may hold only 0, 1 or 3, which give a byte count of 1, 2 or 4 on opb_size_o. A value of 2, or any bit set above bit 1, rejects the trigger: nothing is issued and the access completes at once.
- R5: A trigger with no channel selected, or with both channels selected, issues nothing and completes at once.
- R6: A successful read stores the channel's read data, masked to the access width (upper bytes zero), in the read data register at 0x84 (channel 0) or 0x90 (channel 1).
- R7: A successful transfer sets status bit 16 (channel 0) or bit 17 (channel 1) at 0x48. Writing 1 to a bit clears it and writing 0 leaves it unchanged. irq_o is high while either bit is set.
- R8: A transfer answered by an error updates neither the status register nor the read data register.
- R9: Writing to 0x4C, 0x50 or 0x5C a value other than 0x0011101B, 0x0C330F3F or 0x00030B1B respectively sets cfg_err_o until reset, and the value is stored. Writing the required value, or writing any value to 0x54 or 0x58, does not set it.
- R10: Reads from unmapped word offsets in the 4 KB window return zero. Writes to unmapped offsets and to the read-only version and read data registers change nothing.
- R11: For write transfers, opb_wdata_o carries the write data register with the bytes above the access width forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | AW (12) | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready; low while a transfer is outstanding |
| opb_req_o | output | 2 | Per-channel request, held until acknowledge or error |
| opb_we_o | output | 2 | Per-channel write enable (0 = read) |
| opb_size_o | output | 2x3 | Per-channel byte count (1, 2 or 4) |
| opb_addr_o | output | 2x32 | Per-channel target address |
| opb_wdata_o | output | 2x32 | Per-channel write data, low lanes |
| opb_rdata_i | input | 2x32 | Per-channel returned read data |
| opb_ack_i | input | 2 | Per-channel successful completion |
| opb_err_i | input | 2 | Per-channel error completion |
| irq_o | output | 1 | OR of the two acknowledge status bits |
| cfg_err_o | output | 1 | Sticky endian configuration error |

## Verification
The bench goes after width code 2 and codes with high bits set. A design that decodes only the low two bits would issue a 3-byte transfer or a truncated one instead of rejecting it. It triggers with both channels selected and with neither, where a priority encoder would wrongly pick a channel. It answers with errors after a successful read, so a design that latches data or status on any completion would overwrite the stored word or raise the interrupt. Sub-word reads and writes with dirty upper bytes expose a missing zero-extension or lane mask. Acknowledge delays of zero to two cycles expose a stall that ends one cycle early or late.

// File: rtl/opbb_pkg.sv
package opbb_pkg;
  localparam int DW = 32;
  localparam int NCH = 2;
  localparam int NFLD = 5;
  localparam int NEND = 6;
  localparam int STS_LSB = 16;

  localparam logic [11:0] OFF_VER  = 12'h000;
  localparam logic [11:0] OFF_TRIG = 12'h004;
  localparam logic [11:0] OFF_STS  = 12'h048;
  localparam logic [31:0] VERSION  = 32'h0000_00A1;

  localparam logic [11:0] CH_BASE [NCH] = '{12'h010, 12'h028};
  localparam logic [11:0] CH_RDAT [NCH] = '{12'h084, 12'h090};

  localparam logic [11:0] END_OFF [NEND] = '{12'h04C, 12'h050, 12'h054, 12'h058, 12'h05C, 12'h060};
  localparam logic [31:0] END_RST [NEND] = '{32'h0044EEE4, 32'h0055AAFF, 32'h00117717,
                                              32'hFFAA5500, 32'h0044EEE4, 32'h00117717};
  localparam logic [31:0] END_REQ [NEND] = '{32'h0011101B, 32'h0C330F3F, 32'h0,
                                              32'h0, 32'h00030B1B, 32'h0};
  localparam logic        END_CHK [NEND] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  function automatic logic width_ok(logic [DW-1:0] x);
    return (x[DW-1:2] == '0) && (x[1:0] != 2'b10);
  endfunction

  function automatic logic [DW-1:0] width_mask(logic [1:0] code);
    case (code)
      2'b00:   return 32'h0000_00FF;
      2'b01:   return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/opbb_chan_regs.sv
module opbb_chan_regs
  import opbb_pkg::*;
#(
  parameter int          AW     = 12,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [AW-1:0] RDAT = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] cap_data_i,
  output logic          sel_o,
  output logic          rd_o,
  output logic [DW-1:0] xfer_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          hit_o,
  output logic [DW-1:0] rdat_o
);
  localparam int FSTEP = 4;
  localparam int F_XFER = 2;
  localparam int F_WDAT = 4;

  logic [DW-1:0] fld_q [NFLD];
  logic [DW-1:0] rd_q;

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fld_q[f] <= '0;
      else if (wr_en_i && addr_i == BASE + AW'(FSTEP*f)) fld_q[f] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (cap_i) rd_q <= cap_data_i & width_mask(fld_q[F_XFER][1:0]);
  end

  always_comb begin
    hit_o  = 1'b0;
    rdat_o = '0;
    for (int f = 0; f < NFLD; f++) begin
      if (addr_i == BASE + AW'(FSTEP*f)) begin
        hit_o  = 1'b1;
        rdat_o = fld_q[f];
      end
    end
    if (addr_i == RDAT) begin
      hit_o  = 1'b1;
      rdat_o = rd_q;
    end
  end

  assign sel_o   = fld_q[0][0];
  assign rd_o    = fld_q[1][0];
  assign xfer_o  = fld_q[F_XFER];
  assign addr_o  = fld_q[3];
  assign wdata_o = fld_q[F_WDAT] & width_mask(fld_q[F_XFER][1:0]);

  assert_rd_zext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i && fld_q[F_XFER][1:0] == 2'b00 |=> rd_q[DW-1:8] == '0);
  assert_rd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(rd_q));
endmodule

// File: rtl/opbb_endian_regs.sv
module opbb_endian_regs
  import opbb_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          hit_o,
  output logic [DW-1:0] rdat_o,
  output logic          cfg_err_o
);
  logic [DW-1:0] end_q [NEND];
  logic          err_q, bad;

  for (genvar e = 0; e < NEND; e++) begin : g_end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) end_q[e] <= END_RST[e];
      else if (wr_en_i && addr_i == AW'(END_OFF[e])) end_q[e] <= wdata_i;
    end
  end

  always_comb begin
    hit_o  = 1'b0;
    rdat_o = '0;
    bad    = 1'b0;
    for (int e = 0; e < NEND; e++) begin
      if (addr_i == AW'(END_OFF[e])) begin
        hit_o  = 1'b1;
        rdat_o = end_q[e];
        if (wr_en_i && END_CHK[e] && wdata_i != END_REQ[e]) bad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (bad) err_q <= 1'b1;
  end

  assign cfg_err_o = err_q;

  assert_cfg_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);
endmodule

// File: rtl/opbb_ctrl.sv
module opbb_ctrl
  import opbb_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           trig_i,
  input  logic [NCH-1:0] sel_i,
  input  logic [NCH-1:0] wok_i,
  input  logic [NCH-1:0] rd_i,
  input  logic [NCH-1:0] ack_i,
  input  logic [NCH-1:0] err_i,
  input  logic [NCH-1:0] sts_clr_i,
  output logic           busy_o,
  output logic           launch_o,
  output logic           done_o,
  output logic [NCH-1:0] req_o,
  output logic [NCH-1:0] cap_o,
  output logic [NCH-1:0] sts_o
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic          busy_q;
  logic [CW-1:0] act_q, pick;
  logic          ok;
  logic [NCH-1:0] sts_q;

  always_comb begin
    pick = '0;
    for (int c = 0; c < NCH; c++) if (sel_i[c]) pick = CW'(c);
  end

  assign launch_o = trig_i && !busy_q && ($countones(sel_i) == 1) && wok_i[pick];
  assign done_o   = busy_q && (ack_i[act_q] || err_i[act_q]);
  assign ok       = busy_q && ack_i[act_q] && !err_i[act_q];
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      act_q  <= '0;
    end else if (launch_o) begin
      busy_q <= 1'b1;
      act_q  <= pick;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign req_o[c] = busy_q && (act_q == CW'(c));
    assign cap_o[c] = ok && (act_q == CW'(c)) && rd_i[c];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q[c] <= 1'b0;
      else if (ok && act_q == CW'(c)) sts_q[c] <= 1'b1;
      else if (sts_clr_i[c]) sts_q[c] <= 1'b0;
    end
  end

  assign sts_o = sts_q;

  assert_req_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_o));
  assert_req_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_o) && !done_o |=> $stable(req_o));
  assert_no_pick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && !busy_q && $countones(sel_i) != 1 |=> req_o == '0);
  assert_bad_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i && !busy_q && !wok_i[pick] |=> req_o == '0);
  assert_ack_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok |=> sts_o[act_q]);
  assert_err_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !ok |=> sts_o == $past(sts_o));
endmodule

// File: rtl/opb_bridge.sv
module opb_bridge
  import opbb_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     psel_i,
  input  logic                     penable_i,
  input  logic                     pwrite_i,
  input  logic [AW-1:0]            paddr_i,
  input  logic [DW-1:0]            pwdata_i,
  output logic [DW-1:0]            prdata_o,
  output logic                     pready_o,
  output logic [NCH-1:0]           opb_req_o,
  output logic [NCH-1:0]           opb_we_o,
  output logic [NCH-1:0][2:0]      opb_size_o,
  output logic [NCH-1:0][DW-1:0]   opb_addr_o,
  output logic [NCH-1:0][DW-1:0]   opb_wdata_o,
  input  logic [NCH-1:0][DW-1:0]   opb_rdata_i,
  input  logic [NCH-1:0]           opb_ack_i,
  input  logic [NCH-1:0]           opb_err_i,
  output logic                     irq_o,
  output logic                     cfg_err_o
);
  logic access, wr_en, trig, launch, done, busy;
  logic [DW-1:0] trig_q;
  logic [NCH-1:0] sel, wok, rd, cap, sts, clr, ch_hit;
  logic [DW-1:0] ch_xfer [NCH];
  logic [DW-1:0] ch_rdat [NCH];
  logic end_hit;
  logic [DW-1:0] end_rdat;

  assign access   = psel_i && penable_i;
  assign trig     = access && pwrite_i && paddr_i == AW'(OFF_TRIG);
  assign pready_o = !(launch || (busy && !done));
  assign wr_en    = access && pwrite_i && pready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '0;
    else if (wr_en && paddr_i == AW'(OFF_TRIG)) trig_q <= pwdata_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    opbb_chan_regs #(
      .AW   (AW),
      .BASE (AW'(CH_BASE[c])),
      .RDAT (AW'(CH_RDAT[c]))
    ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en),
      .addr_i     (paddr_i),
      .wdata_i    (pwdata_i),
      .cap_i      (cap[c]),
      .cap_data_i (opb_rdata_i[c]),
      .sel_o      (sel[c]),
      .rd_o       (rd[c]),
      .xfer_o     (ch_xfer[c]),
      .addr_o     (opb_addr_o[c]),
      .wdata_o    (opb_wdata_o[c]),
      .hit_o      (ch_hit[c]),
      .rdat_o     (ch_rdat[c])
    );
    assign wok[c]        = width_ok(ch_xfer[c]);
    assign opb_we_o[c]   = !rd[c];
    assign opb_size_o[c] = {1'b0, ch_xfer[c][1:0]} + 3'd1;
    assign clr[c]        = wr_en && paddr_i == AW'(OFF_STS) && pwdata_i[STS_LSB+c];

    assert_opb_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      opb_req_o[c] && $past(opb_req_o[c]) |-> $stable(opb_addr_o[c]) && $stable(opb_wdata_o[c])
        && $stable(opb_size_o[c]) && $stable(opb_we_o[c]));
  end

  opbb_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig),
    .sel_i     (sel),
    .wok_i     (wok),
    .rd_i      (rd),
    .ack_i     (opb_ack_i),
    .err_i     (opb_err_i),
    .sts_clr_i (clr),
    .busy_o    (busy),
    .launch_o  (launch),
    .done_o    (done),
    .req_o     (opb_req_o),
    .cap_o     (cap),
    .sts_o     (sts)
  );

  opbb_endian_regs #(.AW(AW)) u_endian (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .addr_i    (paddr_i),
    .wdata_i   (pwdata_i),
    .hit_o     (end_hit),
    .rdat_o    (end_rdat),
    .cfg_err_o (cfg_err_o)
  );

  always_comb begin
    prdata_o = '0;
    if (paddr_i == AW'(OFF_VER))       prdata_o = VERSION;
    else if (paddr_i == AW'(OFF_TRIG)) prdata_o = trig_q;
    else if (paddr_i == AW'(OFF_STS))  prdata_o = DW'(sts) << STS_LSB;
    else if (end_hit)                  prdata_o = end_rdat;
    else begin
      for (int c = 0; c < NCH; c++) if (ch_hit[c]) prdata_o = ch_rdat[c];
    end
  end

  assign irq_o = |sts;

  assert_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pready_o && access |-> trig);
endmodule

// File: tb/opb_bridge_bench.sv
module opb_bridge_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready;
  logic [1:0] req, we, ack, err;
  logic [1:0][2:0] size;
  logic [1:0][31:0] oaddr, owdata, ordata;
  logic irq, cfg_err;

  opb_bridge u_opb_bridge (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .opb_req_o(req), .opb_we_o(we), .opb_size_o(size), .opb_addr_o(oaddr),
    .opb_wdata_o(owdata), .opb_rdata_i(ordata), .opb_ack_i(ack), .opb_err_i(err),
    .irq_o(irq), .cfg_err_o(cfg_err)
  );

  int checks = 0, errors = 0, cyc = 0;

  // channel responder
  logic        rsp_err = 0;
  int          rsp_dly = 0;
  int          issue_cnt [2] = '{0, 0};
  logic [1:0]  hs_done = '0;
  int          wcnt [2] = '{0, 0};
  logic [31:0] last_addr, last_wdata;
  logic [2:0]  last_size;
  logic        last_we;

  initial begin
    ack = '0; err = '0; ordata = '0;
  end

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      ack[c] = 1'b0;
      err[c] = 1'b0;
      if (!req[c]) begin
        hs_done[c] = 1'b0;
        wcnt[c] = 0;
      end else if (!hs_done[c]) begin
        if (wcnt[c] == rsp_dly) begin
          if (rsp_err) err[c] = 1'b1; else ack[c] = 1'b1;
          hs_done[c] = 1'b1;
          issue_cnt[c]++;
          last_addr = oaddr[c]; last_wdata = owdata[c];
          last_size = size[c];  last_we = we[c];
        end else wcnt[c]++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apb(input logic w, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int waits);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    waits = 0;
    #1;
    while (!pready) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = prdata;
    @(posedge clk);
    #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r; int w;
    apb(1'b1, a, d, r, w);
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] r; int w;
    apb(1'b0, a, 32'h0, r, w);
    chk(tag, r, exp);
  endtask

  typedef struct packed {
    logic        ch;
    logic        rd;
    logic [31:0] xfer;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] rsp;
    logic        err;
    logic [1:0]  dly;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'd3, 32'h0000_1000, 32'hDEAD_BEEF, 32'h0,         1'b0, 2'd0},
    '{1'b1, 1'b1, 32'd3, 32'h0000_2004, 32'h0,         32'h1234_5678, 1'b0, 2'd1},
    '{1'b0, 1'b1, 32'd0, 32'h0000_0011, 32'h0,         32'hA5A5_A5C3, 1'b0, 2'd2},
    '{1'b1, 1'b1, 32'd1, 32'h0000_0202, 32'h0,         32'hCAFE_F00D, 1'b0, 2'd0},
    '{1'b0, 1'b0, 32'd1, 32'h8000_0010, 32'h1122_3344, 32'h0,         1'b0, 2'd1},
    '{1'b1, 1'b0, 32'd0, 32'hA000_0003, 32'h5566_77EE, 32'h0,         1'b0, 2'd2},
    '{1'b0, 1'b1, 32'd2, 32'h0000_0040, 32'h0,         32'hFFFF_FFFF, 1'b0, 2'd0},
    '{1'b1, 1'b0, 32'd4, 32'h0000_0044, 32'h0BAD_0BAD, 32'h0,         1'b0, 2'd0},
    '{1'b0, 1'b1, 32'd3, 32'h0000_0048, 32'h0,         32'h7777_7777, 1'b1, 2'd1},
    '{1'b1, 1'b1, 32'd0, 32'h0000_004C, 32'h0,         32'h0000_0099, 1'b1, 2'd0}
  };

  localparam logic [11:0] BASE [2] = '{12'h010, 12'h028};
  localparam logic [11:0] RDAT [2] = '{12'h084, 12'h090};

  initial begin
    logic [31:0] model_rd [2];
    logic [31:0] r;
    int w, c0, c1;
    model_rd[0] = 0; model_rd[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 cfg_err", {31'b0, cfg_err}, 0);
    rdchk("R1 version", 12'h000, 32'h0000_00A1);
    rdchk("R1 end 4C", 12'h04C, 32'h0044EEE4);
    rdchk("R1 end 50", 12'h050, 32'h0055AAFF);
    rdchk("R1 end 54", 12'h054, 32'h00117717);
    rdchk("R1 end 58", 12'h058, 32'hFFAA5500);
    rdchk("R1 end 5C", 12'h05C, 32'h0044EEE4);
    rdchk("R1 end 60", 12'h060, 32'h00117717);
    rdchk("R1 status", 12'h048, 0);
    rdchk("R1 ch1 addr", 12'h034, 0);

    // R2 readback
    for (int i = 0; i < 5; i++) begin
      wr(BASE[0] + 12'(4*i), 32'h0100_0000 + i);
      wr(BASE[1] + 12'(4*i), 32'h0200_0000 + i);
    end
    for (int i = 0; i < 5; i++) begin
      rdchk("R2 ch0 field", BASE[0] + 12'(4*i), 32'h0100_0000 + i);
      rdchk("R2 ch1 field", BASE[1] + 12'(4*i), 32'h0200_0000 + i);
    end

    // vector table: R3 R4 R6 R7 R8 R11
    for (int v = 0; v < NV; v++) begin
      automatic vec_t t = VECS[v];
      automatic int ch = int'(t.ch);
      automatic logic issue = (t.xfer[31:2] == 0) && (t.xfer[1:0] != 2'b10);
      automatic logic [31:0] mask = (t.xfer[1:0] == 2'b00) ? 32'hFF :
                                    (t.xfer[1:0] == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
      automatic logic [31:0] exp_sts;
      wr(12'h048, 32'h0003_0000);
      wr(BASE[0], {31'b0, ch == 0});
      wr(BASE[1], {31'b0, ch == 1});
      wr(BASE[ch] + 12'h4, {31'b0, t.rd});
      wr(BASE[ch] + 12'h8, t.xfer);
      wr(BASE[ch] + 12'hC, t.addr);
      wr(BASE[ch] + 12'h10, t.wdata);
      rsp_err = t.err; rsp_dly = int'(t.dly);
      ordata[ch] = t.rsp;
      c0 = issue_cnt[ch];
      apb(1'b1, 12'h004, 32'h1, r, w);
      chk("R4 issue count", issue_cnt[ch] - c0, {31'b0, issue});
      chk("R3 stall cycles", w, issue ? int'(t.dly) + 1 : 0);
      if (issue) begin
        chk("R3 address", last_addr, t.addr);
        chk("R3 direction", {31'b0, last_we}, {31'b0, !t.rd});
        chk("R4 byte count", {29'b0, last_size}, {30'b0, t.xfer[1:0]} + 1);
        if (!t.rd) chk("R11 low lanes", last_wdata, t.wdata & mask);
      end
      if (issue && !t.err && t.rd) model_rd[ch] = t.rsp & mask;
      exp_sts = (issue && !t.err) ? (32'h1 << (16 + ch)) : 0;
      rdchk("R7 R8 status", 12'h048, exp_sts);
      chk("R7 irq", {31'b0, irq}, {31'b0, exp_sts != 0});
      rdchk("R6 R8 read data", RDAT[ch], model_rd[ch]);
    end
    rsp_err = 0; rsp_dly = 0;

    // R5 no select / both selected
    wr(12'h048, 32'h0003_0000);
    wr(BASE[0] + 12'h8, 32'd3); wr(BASE[1] + 12'h8, 32'd3);
    c0 = issue_cnt[0]; c1 = issue_cnt[1];
    wr(BASE[0], 0); wr(BASE[1], 0);
    apb(1'b1, 12'h004, 32'h1, r, w);
    chk("R5 none stall", w, 0);
    wr(BASE[0], 1); wr(BASE[1], 1);
    apb(1'b1, 12'h004, 32'h1, r, w);
    chk("R5 both stall", w, 0);
    chk("R5 no issue", (issue_cnt[0] - c0) + (issue_cnt[1] - c1), 0);
    rdchk("R5 status", 12'h048, 0);

    // R7 W1C per bit
    wr(BASE[1], 0); wr(BASE[0] + 12'h4, 0);
    wr(12'h004, 1);
    wr(BASE[0], 0); wr(BASE[1], 1); wr(BASE[1] + 12'h4, 0);
    wr(12'h004, 1);
    rdchk("R7 both set", 12'h048, 32'h0003_0000);
    wr(12'h048, 32'h0001_0000);
    rdchk("R7 clear bit16", 12'h048, 32'h0002_0000);
    chk("R7 irq held", {31'b0, irq}, 1);
    wr(12'h048, 32'h0000_0000);
    rdchk("R7 zero write", 12'h048, 32'h0002_0000);
    wr(12'h048, 32'h0002_0000);
    chk("R7 irq low", {31'b0, irq}, 0);

    // R9 endian checks
    wr(12'h054, 32'h1234_5678); wr(12'h058, 32'h0);
    wr(12'h04C, 32'h0011101B); wr(12'h050, 32'h0C330F3F); wr(12'h05C, 32'h00030B1B);
    chk("R9 no flag", {31'b0, cfg_err}, 0);
    rdchk("R9 ch1 stored", 12'h054, 32'h1234_5678);
    wr(12'h050, 32'h0000_0001);
    chk("R9 flag set", {31'b0, cfg_err}, 1);
    rdchk("R9 value stored", 12'h050, 32'h0000_0001);
    wr(12'h050, 32'h0C330F3F);
    chk("R9 sticky", {31'b0, cfg_err}, 1);

    // R10 unmapped and read-only
    wr(12'h070, 32'hFFFF_FFFF);
    rdchk("R10 unmapped 070", 12'h070, 0);
    rdchk("R10 unmapped 008", 12'h008, 0);
    rdchk("R10 top of window", 12'hFFC, 0);
    wr(12'h000, 32'h5555_5555);
    rdchk("R10 version ro", 12'h000, 32'h0000_00A1);
    wr(12'h084, 32'h5555_5555);
    rdchk("R10 read data ro", 12'h084, model_rd[0]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule